// File: doc/BRIEF.md
# Message-Addressed Per-Core Vector Interrupt Controller

This block turns message-signalled interrupt writes into per-core vector requests. A write carries no useful payload. Its address alone selects the target core and one of 256 vectors. Each accepted message marks that vector pending for that core. While anything is pending, the core's interrupt line stays high.

Software on a core services its interrupts through a claim port. One claim returns the highest pending vector, removes it from the pending set and marks it in service. When nothing is pending, the claim returns a word with the invalid flag set. A driver therefore drains its core by claiming until it sees the invalid flag. It then retires each serviced vector by writing its number to the core's end-of-interrupt port. The in-service state is visible as four 64-bit words per core.

The message input is a valid/ready channel. `msg_ready` is held high at all times, so the block never applies back-pressure and takes one message in every cycle that `msg_valid` is high. The enable, claim and end-of-interrupt pins are plain strobes.

Top module: `msi_vec_ctrl`

## Requirements
- R1: Address bits [11:4] give the vector and bits [12+CORE_W-1:12] give the core. Bits from 12+CORE_W upward must equal the same bits of `BASE_ADDR`, or the message has no effect and is not counted. Address bits [3:0] and `msg_data` are ignored.
- R2: Messages change state only while the enable bit is set. The enable bit is written from `ctl_en_wdata` on a `ctl_we` strobe and read back on `ctl_en`. Messages that arrive while it is clear are dropped and not counted.
- R3: A message to a vector that is already pending does not queue a second request. That vector is claimed once.
- R4: A claim strobe on core c returns `rd_valid[c]` one cycle later. The 32-bit `rd_data` word carries the vector in bits [7:0] with all other bits zero. If nothing was pending, bit 31 is set instead. When several vectors are pending, the highest-numbered one is claimed first, and back-to-back claims return distinct vectors.
- R5: A claim sets the claimed vector's in-service bit. Vector v of core c sits at bit v%64 of 64-bit word v/64, which is flat bit c*256+v of `isr_words`.
- R6: An `eoi_we[c]` strobe clears in-service bit `eoi_vec` of core c. If a claim of the same vector falls in the same cycle, the claim wins.
- R7: An enabled message to the base address that names a core at or above NUM_CORES is discarded. It increments `err_count`, which saturates at its maximum.
- R8: `irq[c]` is high exactly while core c has at least one pending vector.
- R9: Reset clears all pending and in-service state, the error count and the enable bit.
- R10: A claim sees the pending set as it stood before a message in the same cycle. A message to the vector being claimed in that cycle leaves the vector pending again.
- R11: `msg_ready` is high in every cycle, so each cycle with `msg_valid` high delivers one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message write strobe |
| msg_ready | output | 1 | Message accept, always high |
| msg_addr | input | 32 | Message address carrying the base, core and vector |
| msg_data | input | 32 | Message data word, ignored |
| ctl_we | input | 1 | Enable register write strobe |
| ctl_en_wdata | input | 1 | New enable value |
| ctl_en | output | 1 | Current enable bit |
| rd_req | input | NUM_CORES | Per-core claim strobe |
| rd_data | output | NUM_CORES*32 | Per-core claim result |
| rd_valid | output | NUM_CORES | Claim result valid |
| eoi_we | input | NUM_CORES | Per-core end-of-interrupt strobe |
| eoi_vec | input | NUM_CORES*8 | Vector to retire |
| isr_words | output | NUM_CORES*256 | In-service bits, four 64-bit words per core |
| irq | output | NUM_CORES | Per-core interrupt request |
| err_count | output | ERR_W | Saturating count of messages to absent cores |

## Verification
The delicate overlap is a message landing in the same cycle as a claim on the same core. The bench provokes this by raising `msg_valid` and `rd_req` on the same falling edge. In one case the message targets a vector other than the one pending. In the other it targets exactly the vector that the claim picks. The first claim must return the vector pending before the message. In the second case, `irq` must stay high and a following claim must return the re-sent vector again.

// File: rtl/msi_vec_pkg.sv
package msi_vec_pkg;
  localparam int VEC_W   = 8;
  localparam int NVEC    = 1 << VEC_W;
  localparam int WORD_W  = 64;
  localparam int NWORDS  = NVEC / WORD_W;
  localparam int RSP_W   = 32;
  localparam int INV_BIT = 31;
  localparam int VEC_LSB = 4;
  localparam int CORE_LSB = VEC_LSB + VEC_W;
  localparam logic [RSP_W-1:0] RSP_EMPTY = RSP_W'(1) << INV_BIT;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_vec_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W = 4,
  parameter logic [31:0] BASE_ADDR = 32'h2FE0_0000
) (
  input  logic [31:0]       addr,
  output logic [VEC_W-1:0]  vec,
  output logic [CORE_W-1:0] core,
  output logic              base_hit,
  output logic              core_ok
);
  localparam int TAG_LSB = CORE_LSB + CORE_W;

  assign vec      = addr[CORE_LSB-1:VEC_LSB];
  assign core     = addr[TAG_LSB-1:CORE_LSB];
  assign base_hit = (addr[31:TAG_LSB] == BASE_ADDR[31:TAG_LSB]);
  assign core_ok  = ({1'b0, core} < (CORE_W+1)'(NUM_CORES));
endmodule

// File: rtl/vec_prio_pick.sv
module vec_prio_pick #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_core_bank.sv
module vec_core_bank
  import msi_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_vld,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             claim,
  input  logic             eoi_we,
  input  logic [VEC_W-1:0] eoi_vec,
  output logic [RSP_W-1:0] rsp_data,
  output logic             rsp_vld,
  output logic [NVEC-1:0]  isr,
  output logic             irq
);
  logic [NVEC-1:0]  pend_q, pend_d, isr_q, isr_d;
  logic [VEC_W-1:0] top_vec;
  logic             top_found;
  logic             take;

  vec_prio_pick #(.N(NVEC)) u_pick (
    .req(pend_q), .found(top_found), .idx(top_vec)
  );

  assign take = claim && top_found;

  always_comb begin
    pend_d = pend_q;
    if (take)    pend_d[top_vec] = 1'b0;
    if (set_vld) pend_d[set_vec] = 1'b1;
  end

  always_comb begin
    isr_d = isr_q;
    if (eoi_we) isr_d[eoi_vec] = 1'b0;
    if (take)   isr_d[top_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      isr_q    <= '0;
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
    end else begin
      pend_q  <= pend_d;
      isr_q   <= isr_d;
      rsp_vld <= claim;
      if (claim)
        rsp_data <= top_found ? {{(RSP_W-VEC_W){1'b0}}, top_vec} : RSP_EMPTY;
    end
  end

  assign isr = isr_q;
  assign irq = |pend_q;
endmodule

// File: rtl/msi_vec_ctrl.sv
module msi_vec_ctrl
  import msi_vec_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W = 4,
  parameter logic [31:0] BASE_ADDR = 32'h2FE0_0000,
  parameter int ERR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       msg_valid,
  output logic                       msg_ready,
  input  logic [31:0]                msg_addr,
  input  logic [31:0]                msg_data,
  input  logic                       ctl_we,
  input  logic                       ctl_en_wdata,
  output logic                       ctl_en,
  input  logic [NUM_CORES-1:0]       rd_req,
  output logic [NUM_CORES*RSP_W-1:0] rd_data,
  output logic [NUM_CORES-1:0]       rd_valid,
  input  logic [NUM_CORES-1:0]       eoi_we,
  input  logic [NUM_CORES*VEC_W-1:0] eoi_vec,
  output logic [NUM_CORES*NVEC-1:0]  isr_words,
  output logic [NUM_CORES-1:0]       irq,
  output logic [ERR_W-1:0]           err_count
);
  logic [VEC_W-1:0]  dec_vec;
  logic [CORE_W-1:0] dec_core;
  logic              dec_hit, dec_ok;
  logic              en_q;
  logic              accept;
  logic [ERR_W-1:0]  err_q;
  logic              unused_bits;

  assign unused_bits = ^{msg_data, msg_addr[VEC_LSB-1:0]};

  msi_addr_decode #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(msg_addr), .vec(dec_vec), .core(dec_core),
    .base_hit(dec_hit), .core_ok(dec_ok)
  );

  assign msg_ready = 1'b1;
  assign accept    = msg_valid && en_q && dec_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= '0;
    end else begin
      if (ctl_we) en_q <= ctl_en_wdata;
      if (accept && !dec_ok && err_q != '1) err_q <= err_q + 1'b1;
    end
  end

  assign ctl_en    = en_q;
  assign err_count = err_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit_c;
    assign hit_c = accept && dec_ok && (dec_core == CORE_W'(c));

    vec_core_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_vld(hit_c), .set_vec(dec_vec),
      .claim(rd_req[c]),
      .eoi_we(eoi_we[c]), .eoi_vec(eoi_vec[c*VEC_W +: VEC_W]),
      .rsp_data(rd_data[c*RSP_W +: RSP_W]), .rsp_vld(rd_valid[c]),
      .isr(isr_words[c*NVEC +: NVEC]), .irq(irq[c])
    );
  end
endmodule

// File: rtl/msi_vec_ctrl_chk.sv
module msi_vec_ctrl_chk
  import msi_vec_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ERR_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       msg_valid,
  input logic                       ctl_en,
  input logic [NUM_CORES-1:0]       rd_req,
  input logic [NUM_CORES*RSP_W-1:0] rd_data,
  input logic [NUM_CORES-1:0]       rd_valid,
  input logic [NUM_CORES*NVEC-1:0]  isr_words,
  input logic [NUM_CORES-1:0]       irq,
  input logic [ERR_W-1:0]           err_count
);
  // R2
  disabled_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(err_count));

  // R7
  err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> err_count >= $past(err_count));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    // R4
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[c] && !irq[c] |=> rd_valid[c] && rd_data[c*RSP_W + INV_BIT]);

    // R8
    busy_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[c] && irq[c] |=> rd_valid[c] && !rd_data[c*RSP_W + INV_BIT]);

    // R5
    claim_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[c] && irq[c] |=> isr_words[c*NVEC + int'(rd_data[c*RSP_W +: VEC_W])]);
  end
endmodule

bind msi_vec_ctrl msi_vec_ctrl_chk #(.NUM_CORES(NUM_CORES), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .ctl_en(ctl_en),
  .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
  .isr_words(isr_words), .irq(irq), .err_count(err_count)
);

// File: tb/msi_vec_ctrl_test.sv
module msi_vec_ctrl_test;
  localparam int NC = 2;
  localparam logic [31:0] BASE = 32'h2FE0_0000;
  localparam logic [1:0] OP_MSG = 2'd1, OP_RD = 2'd2;
  localparam logic [8:0] XINV = 9'h100;

  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_ready;
  logic [31:0] msg_addr = 0, msg_data = 0;
  logic ctl_we = 0, ctl_en_wdata = 0, ctl_en;
  logic [NC-1:0] rd_req = 0, rd_valid, eoi_we = 0, irq;
  logic [NC*32-1:0] rd_data;
  logic [NC*8-1:0] eoi_vec = 0;
  logic [NC*256-1:0] isr_words;
  logic [7:0] err_count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_vec_ctrl uut (.*);

  // op[22:21] core[20:17] vec[16:9] exp[8:0]
  localparam logic [22:0] TBL [14] = '{
    {OP_MSG, 4'd0, 8'd5,   9'd0},
    {OP_MSG, 4'd0, 8'd200, 9'd0},
    {OP_MSG, 4'd0, 8'd5,   9'd0},
    {OP_MSG, 4'd1, 8'd17,  9'd0},
    {OP_RD,  4'd0, 8'd0,   9'd200},
    {OP_RD,  4'd0, 8'd0,   9'd5},
    {OP_RD,  4'd0, 8'd0,   XINV},
    {OP_RD,  4'd1, 8'd0,   9'd17},
    {OP_RD,  4'd1, 8'd0,   XINV},
    {OP_MSG, 4'd1, 8'd0,   9'd0},
    {OP_MSG, 4'd1, 8'd255, 9'd0},
    {OP_RD,  4'd1, 8'd0,   9'd255},
    {OP_RD,  4'd1, 8'd0,   9'd0},
    {OP_RD,  4'd1, 8'd0,   XINV}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int core, input int vec);
    return BASE | (32'(core) << 12) | (32'(vec) << 4);
  endfunction

  task automatic send(input logic [31:0] a);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = 32'hDEAD_BEEF;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic claim(input int c, output logic [31:0] d);
    @(negedge clk); rd_req[c] = 1;
    @(negedge clk); rd_req[c] = 0;
    d = rd_data[c*32 +: 32];
  endtask

  task automatic eoi(input int c, input int v);
    @(negedge clk); eoi_we[c] = 1; eoi_vec[c*8 +: 8] = 8'(v);
    @(negedge clk); eoi_we[c] = 0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); ctl_we = 1; ctl_en_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  function automatic bit rsp_ok(input logic [31:0] d, input logic [8:0] x);
    if (x[8]) return d[31];
    return d == {24'h0, x[7:0]};
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check(ctl_en == 0, "R9 enable", ctl_en, 0);
    check(irq == 0 && isr_words == 0 && err_count == 0, "R9 state", irq, 0);
    // R11
    check(msg_ready == 1, "R11 ready", msg_ready, 1);
    // R2: disabled drop
    send(mk(0, 33));
    send(mk(7, 1));
    check(irq == 0, "R2 drop while disabled", irq, 0);
    check(err_count == 0, "R2 no count while disabled", err_count, 0);
    claim(0, d);
    check(d[31] && rd_valid[0], "R2 claim after drop", d, 32'h8000_0000);
    set_en(1);
    check(ctl_en == 1, "R2 enable readback", ctl_en, 1);

    // table walk: R1 R3 R4 R8
    foreach (TBL[i]) begin
      logic [22:0] e;
      e = TBL[i];
      if (e[22:21] == OP_MSG) begin
        send(mk(int'(e[20:17]), int'(e[16:9])));
        check(irq[e[20:17]] == 1, "R8 irq after message", irq, 1);
      end else begin
        claim(int'(e[20:17]), d);
        check(rsp_ok(d, e[8:0]), "R4 R3 claim order", d, e[8:0]);
      end
    end
    check(irq == 0, "R8 irq low after drain", irq, 0);

    // R5: layout, core0 vec 200 in word 3 bit 8
    check(isr_words[3*64 + 8] && isr_words[5], "R5 in-service core0", isr_words[255:0], 0);
    check(isr_words[256 + 17] && isr_words[256 + 255] && isr_words[256], "R5 in-service core1", isr_words[511:256], 0);
    // R6
    eoi(0, 200);
    check(!isr_words[200] && isr_words[5], "R6 eoi clears one bit", isr_words[255:0], 32);

    // R7: absent cores 2 and 3
    send(mk(2, 9));
    send(mk(3, 9));
    check(err_count == 2, "R7 error count", err_count, 2);
    check(irq == 0, "R7 absent core dropped", irq, 0);
    // R1: base mismatch and low address bits
    send(mk(0, 40) ^ 32'h0001_0000);
    check(irq == 0 && err_count == 2, "R1 base mismatch", irq, 0);
    send(mk(1, 77) | 32'h0000_000F);
    claim(1, d);
    check(d == 32'd77, "R1 low bits ignored", d, 77);

    // R10: message to other vector in claim cycle
    send(mk(0, 9));
    @(negedge clk); rd_req[0] = 1; msg_valid = 1; msg_addr = mk(0, 20);
    @(negedge clk); rd_req[0] = 0; msg_valid = 0;
    check(rd_data[31:0] == 32'd9, "R10 claim ignores same-cycle message", rd_data[31:0], 9);
    // R10: message to claimed vector re-arms it
    @(negedge clk); rd_req[0] = 1; msg_valid = 1; msg_addr = mk(0, 20);
    @(negedge clk); rd_req[0] = 0; msg_valid = 0;
    check(rd_data[31:0] == 32'd20, "R10 claim value", rd_data[31:0], 20);
    check(irq[0] == 1, "R10 vector stays pending", irq[0], 1);
    claim(0, d);
    check(d == 32'd20, "R10 re-armed vector", d, 20);

    // R9: reset clears everything
    send(mk(1, 3));
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(irq == 0 && isr_words == 0 && err_count == 0 && ctl_en == 0, "R9 reset clears", irq, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule